// File: doc/BRIEF.md
# DDR Region Security Filter

This block keeps the region-based security settings for a DDR address space and checks each transaction against them. The space is cut into 1 MB pages. Software defines up to eight windows through a start page and an inclusive end page for each. It marks each window secure or open, and it decides whether memory outside every secure window is protected too. A single bypass bit opens all of memory at once.

Configuration uses a small register port. Each 32-bit write carries a per-bit write enable in its upper half for the 16 data bits in its lower half, so one field can be changed without disturbing its neighbours. The check port is combinational. An interconnect presents the address and the non-secure attribute of a transaction, and in the same cycle it gets a deny flag that it can turn into an error response.

The register index map is fixed. Indices 0 to 7 hold the start pages of windows 0 to 7. Indices 8 to 15 hold the end pages of windows 0 to 7. Index 16 is the control word. In the control word, bits 7:0 are the per-window secure enables, bit 8 is the outside-memory secure enable and bit 9 is the global bypass. The page of an address is addr[ADDR_W-1:20], and ADDR_W-20 must not exceed 16.

Top module: `ddr_sec_filter`

## Requirements
- R1: After reset every register reads as zero, and no access is denied.
- R2: A write to index i updates data bit b (b in 0..15) of register i only when wdata bit 16+b is 1. Every other bit keeps its value.
- R3: A read returns the 16-bit register in bits 15:0 with bits 31:16 zero. An index above 16 reads as zero, and a write to such an index changes no register.
- R4: Window r matches an address when start_r <= page <= end_r, with both bounds inclusive. Start 0 with end 0 covers 0x0 to 0xFFFFF, and start 0 with end 31 covers the first 32 MB.
- R5: Only windows whose control bit r is 1 count as hits. With no enables set and bit 8 at 0, nothing is denied.
- R6: When control bit 8 is 1, a non-secure access that hits no enabled window is denied. This includes an address inside a window whose enable is 0.
- R7: When control bit 9 is 1, no access is denied, whatever the other bits hold.
- R8: An access with the non-secure flag at 0 is never denied.
- R9: The deny output follows the check inputs in the same cycle, with no register on the path.
- R10: A window whose start page is above its end page matches no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 5 | Register index for both read and write |
| reg_wdata_i | input | 32 | Write enables in bits 31:16, data in bits 15:0 |
| reg_rdata_o | output | 32 | Read data of the register at reg_idx_i |
| chk_addr_i | input | 32 | Address of the transaction under check |
| chk_ns_i | input | 1 | 1 for a non-secure transaction |
| chk_deny_o | output | 1 | 1 when the transaction must be blocked |

## Verification
The bench builds the block with its default parameters: eight windows, a 32-bit address and 1 MB pages. This gives 12-bit page numbers, so window edges at pages 0, 63, 64, 210 and 211 can be reached with plain addresses. With eight windows the control word also leaves spare bits above the bypass. The vectors place an empty window (start above end) and a disabled window next to enabled ones, so that the outside-memory enable can be seen to cover the disabled window's pages.

// File: rtl/ddr_sec_pkg.sv
package ddr_sec_pkg;
  localparam int unsigned REG_W = 16;

  typedef logic [REG_W-1:0] reg_word_t;

  function automatic reg_word_t masked_update(reg_word_t old_v, reg_word_t mask_v,
                                              reg_word_t new_v);
    return (old_v & ~mask_v) | (new_v & mask_v);
  endfunction
endpackage

// File: rtl/ddr_sec_regfile.sv
module ddr_sec_regfile
  import ddr_sec_pkg::*;
#(
  parameter int unsigned NUM_REG = 17,
  parameter int unsigned IDX_W   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [2*REG_W-1:0]       wdata_i,
  output logic [2*REG_W-1:0]       rdata_o,
  output logic [NUM_REG*REG_W-1:0] regs_o
);
  reg_word_t regs_q [NUM_REG];
  reg_word_t wmask, wval;

  assign wmask = wdata_i[2*REG_W-1:REG_W];
  assign wval  = wdata_i[REG_W-1:0];

  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[i] <= '0;
      end else if (we_i && (idx_i == IDX_W'(i))) begin
        regs_q[i] <= masked_update(regs_q[i], wmask, wval);
      end
    end
    assign regs_o[i*REG_W +: REG_W] = regs_q[i];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REG; i++) begin
      if (idx_i == IDX_W'(i)) rdata_o[REG_W-1:0] = regs_q[i];
    end
  end
endmodule

// File: rtl/ddr_sec_rgn_match.sv
module ddr_sec_rgn_match
  import ddr_sec_pkg::*;
#(
  parameter int unsigned NUM_RGN = 8,
  parameter int unsigned PAGE_W  = 12
) (
  input  logic [PAGE_W-1:0]        page_i,
  input  logic [NUM_RGN*REG_W-1:0] start_i,
  input  logic [NUM_RGN*REG_W-1:0] end_i,
  output logic [NUM_RGN-1:0]       in_rgn_o
);
  reg_word_t page_ext;
  assign page_ext = REG_W'(page_i);

  for (genvar r = 0; r < NUM_RGN; r++) begin : g_rgn
    reg_word_t lo, hi;
    assign lo = start_i[r*REG_W +: REG_W];
    assign hi = end_i[r*REG_W +: REG_W];
    // inclusive bounds; lo > hi yields no match
    assign in_rgn_o[r] = (page_ext >= lo) && (page_ext <= hi);
  end
endmodule

// File: rtl/ddr_sec_decide.sv
module ddr_sec_decide #(
  parameter int unsigned NUM_RGN = 8
) (
  input  logic [NUM_RGN-1:0] in_rgn_i,
  input  logic [NUM_RGN-1:0] rgn_en_i,
  input  logic               outside_en_i,
  input  logic               bypass_i,
  input  logic               ns_i,
  output logic               deny_o
);
  logic any_hit;
  // a window only counts when enabled; otherwise the page is "outside"
  assign any_hit = |(in_rgn_i & rgn_en_i);
  assign deny_o  = ns_i && !bypass_i && (any_hit || outside_en_i);
endmodule

// File: rtl/ddr_sec_filter.sv
module ddr_sec_filter
  import ddr_sec_pkg::*;
#(
  parameter int unsigned NUM_RGN    = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned GRAN_SHIFT = 20,
  parameter int unsigned IDX_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic              chk_ns_i,
  output logic              chk_deny_o
);
  localparam int unsigned NUM_REG  = 2 * NUM_RGN + 1;
  localparam int unsigned CTRL_IDX = 2 * NUM_RGN;
  localparam int unsigned PAGE_W   = ADDR_W - GRAN_SHIFT;
  localparam int unsigned OUT_BIT  = NUM_RGN;
  localparam int unsigned BYP_BIT  = NUM_RGN + 1;

  logic [NUM_REG*REG_W-1:0] regs_flat;
  reg_word_t                ctrl;
  logic [NUM_RGN-1:0]       in_rgn;
  logic [PAGE_W-1:0]        page;
  logic                     addr_unused;

  ddr_sec_regfile #(
    .NUM_REG(NUM_REG),
    .IDX_W  (IDX_W)
  ) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .idx_i  (reg_idx_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .regs_o (regs_flat)
  );

  assign ctrl        = regs_flat[CTRL_IDX*REG_W +: REG_W];
  assign page        = chk_addr_i[ADDR_W-1:GRAN_SHIFT];
  assign addr_unused = ^chk_addr_i[GRAN_SHIFT-1:0];

  if (BYP_BIT + 1 < REG_W) begin : g_spare
    logic ctrl_unused;
    assign ctrl_unused = ^ctrl[REG_W-1:BYP_BIT+1];
  end

  ddr_sec_rgn_match #(
    .NUM_RGN(NUM_RGN),
    .PAGE_W (PAGE_W)
  ) i_match (
    .page_i  (page),
    .start_i (regs_flat[0 +: NUM_RGN*REG_W]),
    .end_i   (regs_flat[NUM_RGN*REG_W +: NUM_RGN*REG_W]),
    .in_rgn_o(in_rgn)
  );

  ddr_sec_decide #(
    .NUM_RGN(NUM_RGN)
  ) i_decide (
    .in_rgn_i    (in_rgn),
    .rgn_en_i    (ctrl[NUM_RGN-1:0]),
    .outside_en_i(ctrl[OUT_BIT]),
    .bypass_i    (ctrl[BYP_BIT]),
    .ns_i        (chk_ns_i),
    .deny_o      (chk_deny_o)
  );
endmodule

// File: rtl/ddr_sec_filter_chk.sv
module ddr_sec_filter_chk
  import ddr_sec_pkg::*;
#(
  parameter int unsigned NUM_RGN = 8,
  parameter int unsigned IDX_W   = 5
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                reg_we_i,
  input logic [IDX_W-1:0]                    reg_idx_i,
  input logic [31:0]                         reg_wdata_i,
  input logic                                chk_ns_i,
  input logic                                chk_deny_o,
  input logic [(2*NUM_RGN+1)*REG_W-1:0]      regs_flat
);
  localparam int unsigned NUM_REG  = 2 * NUM_RGN + 1;
  localparam int unsigned CTRL_IDX = 2 * NUM_RGN;

  reg_word_t ctrl, cur_v, exp_v;
  logic      idx_ok;

  assign ctrl   = regs_flat[CTRL_IDX*REG_W +: REG_W];
  assign idx_ok = int'(reg_idx_i) < NUM_REG;

  always_comb begin
    cur_v = '0;
    for (int i = 0; i < NUM_REG; i++) begin
      if (reg_idx_i == IDX_W'(i)) cur_v = regs_flat[i*REG_W +: REG_W];
    end
  end
  assign exp_v = masked_update(cur_v, reg_wdata_i[31:16], reg_wdata_i[15:0]);

  assert_masked_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && idx_ok) |=> (cur_v == $past(exp_v)) || ($past(reg_idx_i) != reg_idx_i));

  assert_bad_index_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !idx_ok) |=> $stable(regs_flat));

  assert_no_enable_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[NUM_RGN:0] == '0) |-> !chk_deny_o);

  assert_bypass_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[NUM_RGN+1] |-> !chk_deny_o);

  assert_secure_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_ns_i |-> !chk_deny_o);
endmodule

bind ddr_sec_filter ddr_sec_filter_chk #(
  .NUM_RGN(NUM_RGN),
  .IDX_W  (IDX_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_idx_i  (reg_idx_i),
  .reg_wdata_i(reg_wdata_i),
  .chk_ns_i   (chk_ns_i),
  .chk_deny_o (chk_deny_o),
  .regs_flat  (regs_flat)
);

// File: tb/test_ddr_sec_filter.sv
module test_ddr_sec_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [31:0] chk_addr_i = '0;
  logic        chk_ns_i = 1'b0;
  logic        chk_deny_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ddr_sec_filter i_ddr_sec_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_idx_i  (reg_idx_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .chk_addr_i (chk_addr_i),
    .chk_ns_i   (chk_ns_i),
    .chk_deny_o (chk_deny_o)
  );

  typedef struct packed {
    logic [15:0] ctrl;
    logic [31:0] addr;
    logic        ns;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  // windows: w0 = [0,0], w1 = [32,63], w2 = [100,99] empty, w3 = [200,210]
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{16'h0007, 32'h0000_0000, 1'b1, 1'b1, 4'd4},
    '{16'h0007, 32'h000F_FFFF, 1'b1, 1'b1, 4'd4},
    '{16'h0007, 32'h0010_0000, 1'b1, 1'b0, 4'd4},
    '{16'h0007, 32'h0200_0000, 1'b1, 1'b1, 4'd4},
    '{16'h0007, 32'h03FF_FFFF, 1'b1, 1'b1, 4'd4},
    '{16'h0007, 32'h0400_0000, 1'b1, 1'b0, 4'd4},
    '{16'h0007, 32'h0000_0000, 1'b0, 1'b0, 4'd8},
    '{16'h0007, 32'h0640_0000, 1'b1, 1'b0, 4'd10},
    '{16'h0007, 32'h0CD0_0000, 1'b1, 1'b0, 4'd5},
    '{16'h0008, 32'h0D2F_FFFF, 1'b1, 1'b1, 4'd5},
    '{16'h0008, 32'h0D30_0000, 1'b1, 1'b0, 4'd5},
    '{16'h0107, 32'h0CD0_0000, 1'b1, 1'b1, 4'd6},
    '{16'h0107, 32'h0010_0000, 1'b1, 1'b1, 4'd6},
    '{16'h0107, 32'h0640_0000, 1'b1, 1'b1, 4'd6},
    '{16'h0100, 32'h0000_0000, 1'b1, 1'b1, 4'd6},
    '{16'h0107, 32'h0CD0_0000, 1'b0, 1'b0, 4'd8},
    '{16'h0207, 32'h0000_0000, 1'b1, 1'b0, 4'd7},
    '{16'h0307, 32'h0CD0_0000, 1'b1, 1'b0, 4'd7}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] idx, logic [15:0] mask, logic [15:0] data);
    @(negedge clk_i);
    reg_we_i    = 1'b1;
    reg_idx_i   = idx;
    reg_wdata_i = {mask, data};
    @(negedge clk_i);
    reg_we_i    = 1'b0;
  endtask

  task automatic rd(logic [4:0] idx, output logic [31:0] v);
    @(negedge clk_i);
    reg_idx_i = idx;
    #1 v = reg_rdata_o;
  endtask

  task automatic probe(logic [31:0] a, logic ns);
    chk_addr_i = a;
    chk_ns_i   = ns;
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    rd(5'd0, v);  check("R1 start0", v, 32'h0);
    rd(5'd16, v); check("R1 ctrl", v, 32'h0);
    probe(32'h0000_0000, 1'b1);
    check("R1 deny", {31'b0, chk_deny_o}, 32'h0);

    // R2: masked writes
    wr(5'd5, 16'h00FF, 16'hABCD);
    rd(5'd5, v); check("R2 low byte", v, 32'h0000_00CD);
    wr(5'd5, 16'hF000, 16'h1234);
    rd(5'd5, v); check("R2 keep others", v, 32'h0000_10CD);
    wr(5'd5, 16'h0000, 16'hFFFF);
    rd(5'd5, v); check("R2 zero mask", v, 32'h0000_10CD);

    // R3: out-of-range index
    wr(5'd20, 16'hFFFF, 16'h5555);
    rd(5'd20, v); check("R3 bad idx read", v, 32'h0);
    rd(5'd16, v); check("R3 ctrl untouched", v, 32'h0);
    rd(5'd5, v);  check("R3 reg untouched", v, 32'h0000_10CD);
    wr(5'd5, 16'hFFFF, 16'h0000);

    // window setup for the vector walk
    wr(5'd0, 16'hFFFF, 16'd0);   wr(5'd8, 16'hFFFF, 16'd0);
    wr(5'd1, 16'hFFFF, 16'd32);  wr(5'd9, 16'hFFFF, 16'd63);
    wr(5'd2, 16'hFFFF, 16'd100); wr(5'd10, 16'hFFFF, 16'd99);
    wr(5'd3, 16'hFFFF, 16'd200); wr(5'd11, 16'hFFFF, 16'd210);
    rd(5'd9, v); check("R3 end read", v, 32'd63);

    // R4 R5 R6 R7 R8 R10 vectors
    for (int i = 0; i < NV; i++) begin
      wr(5'd16, 16'hFFFF, VECS[i].ctrl);
      probe(VECS[i].addr, VECS[i].ns);
      total++;
      if (chk_deny_o !== VECS[i].exp) begin
        bad++;
        $display("FAIL R%0d vec %0d actual=%b expected=%b", VECS[i].req, i,
                 chk_deny_o, VECS[i].exp);
      end
    end

    // R9: deny follows the inputs within the same cycle
    wr(5'd16, 16'hFFFF, 16'h0001);
    @(negedge clk_i);
    probe(32'h0000_0000, 1'b1);
    check("R9 assert", {31'b0, chk_deny_o}, 32'h1);
    probe(32'h0010_0000, 1'b1);
    check("R9 release", {31'b0, chk_deny_o}, 32'h0);

    // R7: bypass set through a mask that touches only bit 9
    wr(5'd16, 16'h0200, 16'hFFFF);
    rd(5'd16, v); check("R7 ctrl", v, 32'h0000_0201);
    probe(32'h0000_0000, 1'b1);
    check("R7 open", {31'b0, chk_deny_o}, 32'h0);

    // R1: reset in mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(5'd9, v);  check("R1 end cleared", v, 32'h0);
    rd(5'd16, v); check("R1 ctrl cleared", v, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule